// File: doc/BRIEF.md
# Start-Gap Wear-Leveling Row Remapper

This block sits in front of a wear-prone row-organised memory and rotates the mapping from logical rows to physical rows so that heavily written addresses do not wear out one physical row. The physical array holds one more row than the logical space. The extra row is the movable gap. Each incoming request has its logical row translated through two registers, a start offset and a gap position. The translated request leaves on a registered output one cycle after it is accepted.

Accepted writes are counted against a programmable interval. When the count reaches the interval, the block issues a row-copy command to an external copy engine. The command moves the row just below the gap into the gap. The block then holds off new requests until the engine reports completion, and only then moves the gap down by one row. When the gap steps past row zero it jumps back to the top row and the start offset advances. After the gap has visited every physical row, every logical row lands one physical row further on. An interval of zero turns wear levelling off and lets rows pass through unchanged.

Top module: `startgap_remapper`

## Requirements
- R1: After reset the start offset is 0 and the gap is at physical row ROWS, so logical row n maps to physical row n. Also after reset, req_ready is 1, out_valid is 0 and copy_valid is 0.
- R2: With a nonzero interval, an accepted logical row n maps to physical row p = (n + start) mod ROWS. The result is p + 1 when p is greater than or equal to the gap position, so the result never equals the gap.
- R3: A request is accepted on a clock edge where req_valid and req_ready are both 1. On the next cycle out_valid is 1, and out_write and out_prow carry the translation. out_valid is 0 in every cycle after an edge with no acceptance.
- R4: Only accepted writes are counted, and only while the interval is nonzero. The accepted write that brings the count to the interval clears the count, and copy_valid rises in the following cycle. Reads never cause a copy.
- R5: A copy command has copy_dst equal to the current gap. copy_src is gap − 1, or ROWS when the gap is 0.
- R6: copy_valid, copy_src and copy_dst stay unchanged until an edge where copy_done is 1. req_ready is 0 from the cycle copy_valid rises until the cycle after copy_done is taken.
- R7: On completion the gap decrements by one. When the gap was 0, it becomes ROWS and the start offset advances by one modulo ROWS.
- R8: While the interval is 0, out_prow equals the logical row, no copy is issued and the write count stays cleared.
- R9: The write that triggers a copy is translated with the mapping in force before the gap moves, and its output appears in the same cycle that copy_valid rises.
- R10: From reset with interval G, after (ROWS + 1) × G writes and their copies, every logical row n maps to physical row (n + 1) mod ROWS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interval | input | IVL_W | Writes between gap moves; 0 bypasses remapping |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for write, 0 for read |
| req_lrow | input | LA_W | Logical row of the request |
| out_valid | output | 1 | Translated request present |
| out_write | output | 1 | Write flag of the translated request |
| out_prow | output | PA_W | Physical row of the translated request |
| copy_valid | output | 1 | Row-copy command outstanding |
| copy_src | output | PA_W | Physical row to read |
| copy_dst | output | PA_W | Physical row to write (the gap) |
| copy_done | input | 1 | Copy engine finished the outstanding copy |

## Verification
The interval-completing write can be translated and handed out in the same cycle that its copy command appears. That output must use the old gap even though the gap is about to move. The bench provokes this with short intervals, including an interval of 1 where every write triggers a copy. It also varies the copy engine's completion delay from zero to three extra cycles. A reference model kept in integers predicts the output row, the copy fields and the ready line for every cycle, and it flags any request that is accepted during the stall.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic {
    CP_IDLE = 1'b0,
    CP_BUSY = 1'b1
  } cp_state_e;
endpackage

// File: rtl/sg_translate.sv
module sg_translate #(
  parameter int ROWS = 16,
  parameter int LA_W = $clog2(ROWS),
  parameter int PA_W = $clog2(ROWS + 1)
) (
  input  logic [LA_W-1:0] lrow,
  input  logic [LA_W-1:0] start,
  input  logic [PA_W-1:0] gap,
  input  logic            bypass,
  output logic [PA_W-1:0] prow
);
  localparam bit POW2 = ((1 << LA_W) == ROWS);
  localparam logic [LA_W:0] ROWS_S = (LA_W+1)'(ROWS);

  logic [LA_W:0]   sum;
  logic [LA_W-1:0] wrapped;
  logic [PA_W-1:0] wide;

  assign sum = {1'b0, lrow} + {1'b0, start};

  generate
    if (POW2) begin : g_mask_wrap
      assign wrapped = sum[LA_W-1:0];
    end else begin : g_sub_wrap
      logic [LA_W:0] reduced;
      assign reduced = (sum >= ROWS_S) ? (sum - ROWS_S) : sum;
      assign wrapped = reduced[LA_W-1:0];
    end
  endgenerate

  assign wide = PA_W'(wrapped);

  always_comb begin
    if (bypass)           prow = PA_W'(lrow);
    else if (wide >= gap) prow = wide + PA_W'(1);
    else                  prow = wide;
  end
endmodule

// File: rtl/sg_write_counter.sv
module sg_write_counter #(
  parameter int IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IVL_W-1:0] interval,
  input  logic             wr_acc,
  output logic             hit
);
  logic [IVL_W-1:0] count;
  logic [IVL_W:0]   next_count;

  assign next_count = {1'b0, count} + (IVL_W+1)'(1);
  assign hit = wr_acc && (interval != '0) && (next_count >= {1'b0, interval});

  always_ff @(posedge clk) begin
    if (rst || interval == '0) begin
      count <= '0;
    end else if (wr_acc) begin
      if (hit) count <= '0;
      else     count <= next_count[IVL_W-1:0];
    end
  end

  // R8
  zero_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (interval == '0) |=> (count == '0));
endmodule

// File: rtl/sg_gap_ctrl.sv
module sg_gap_ctrl
  import sg_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int LA_W = $clog2(ROWS),
  parameter int PA_W = $clog2(ROWS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trigger,
  input  logic            done,
  output logic [LA_W-1:0] start,
  output logic [PA_W-1:0] gap,
  output logic            cp_valid,
  output logic [PA_W-1:0] cp_src,
  output logic [PA_W-1:0] cp_dst
);
  localparam logic [PA_W-1:0] TOP_ROW   = PA_W'(ROWS);
  localparam logic [LA_W-1:0] LAST_LROW = LA_W'(ROWS - 1);

  cp_state_e state;

  assign cp_valid = (state == CP_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CP_IDLE;
      start  <= '0;
      gap    <= TOP_ROW;
      cp_src <= '0;
      cp_dst <= '0;
    end else begin
      case (state)
        CP_IDLE: begin
          if (trigger) begin
            state  <= CP_BUSY;
            cp_dst <= gap;
            cp_src <= (gap == '0) ? TOP_ROW : (gap - PA_W'(1));
          end
        end
        CP_BUSY: begin
          if (done) begin
            state <= CP_IDLE;
            if (gap == '0) begin
              gap   <= TOP_ROW;
              start <= (start == LAST_LROW) ? '0 : (start + LA_W'(1));
            end else begin
              gap <= gap - PA_W'(1);
            end
          end
        end
        default: state <= CP_IDLE;
      endcase
    end
  end

  // R6
  copy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_valid && !done) |=> (cp_valid && $stable(cp_src) && $stable(cp_dst)));

  // R7
  gap_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_valid && done && gap != '0) |=> (gap == $past(gap) - PA_W'(1) && $stable(start)));

  // R7
  gap_range_chk: assert property (@(posedge clk) disable iff (rst)
    (gap <= TOP_ROW));
endmodule

// File: rtl/startgap_remapper.sv
module startgap_remapper #(
  parameter int ROWS  = 16,
  parameter int IVL_W = 8,
  parameter int LA_W  = $clog2(ROWS),
  parameter int PA_W  = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IVL_W-1:0] cfg_interval,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [LA_W-1:0]  req_lrow,
  output logic             out_valid,
  output logic             out_write,
  output logic [PA_W-1:0]  out_prow,
  output logic             copy_valid,
  output logic [PA_W-1:0]  copy_src,
  output logic [PA_W-1:0]  copy_dst,
  input  logic             copy_done
);
  logic            accept;
  logic            wr_hit;
  logic            bypass;
  logic [LA_W-1:0] start;
  logic [PA_W-1:0] gap;
  logic [PA_W-1:0] prow_next;

  assign req_ready = !copy_valid;
  assign accept    = req_valid && req_ready;
  assign bypass    = (cfg_interval == '0);

  sg_translate #(.ROWS(ROWS), .LA_W(LA_W), .PA_W(PA_W)) xlate_i (
    .lrow(req_lrow), .start(start), .gap(gap), .bypass(bypass), .prow(prow_next)
  );

  sg_write_counter #(.IVL_W(IVL_W)) wcnt_i (
    .clk(clk), .rst(rst), .interval(cfg_interval),
    .wr_acc(accept && req_write), .hit(wr_hit)
  );

  sg_gap_ctrl #(.ROWS(ROWS), .LA_W(LA_W), .PA_W(PA_W)) gapc_i (
    .clk(clk), .rst(rst), .trigger(wr_hit), .done(copy_done),
    .start(start), .gap(gap), .cp_valid(copy_valid),
    .cp_src(copy_src), .cp_dst(copy_dst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_write <= 1'b0;
      out_prow  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_write <= req_write;
        out_prow  <= prow_next;
      end
    end
  end

  // R2
  prow_avoids_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !bypass) |=> (out_prow != gap));

  // R4
  copy_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(copy_valid) |-> $past(accept && req_write));

  // R9
  copy_with_output_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(copy_valid) |-> (out_valid && out_write));

  // R8
  bypass_no_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (bypass && !copy_valid) |=> !copy_valid);
endmodule

// File: tb/startgap_remapper_tb.sv
module startgap_remapper_tb_top;
  localparam int ROWS = 16;
  localparam int IVL_W = 8;
  localparam int LA_W = $clog2(ROWS);
  localparam int PA_W = $clog2(ROWS + 1);

  logic clk = 0;
  logic rst = 1;
  logic [IVL_W-1:0] cfg_interval = 4;
  logic req_valid = 0;
  logic req_ready;
  logic req_write = 0;
  logic [LA_W-1:0] req_lrow = 0;
  logic out_valid, out_write;
  logic [PA_W-1:0] out_prow;
  logic copy_valid;
  logic [PA_W-1:0] copy_src, copy_dst;
  logic copy_done = 0;

  always #5 clk = ~clk;

  startgap_remapper #(.ROWS(ROWS), .IVL_W(IVL_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_interval(cfg_interval),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_lrow(req_lrow), .out_valid(out_valid), .out_write(out_write),
    .out_prow(out_prow), .copy_valid(copy_valid), .copy_src(copy_src),
    .copy_dst(copy_dst), .copy_done(copy_done)
  );

  int total = 0;
  int bad = 0;
  int copies_seen = 0;
  bit prev_cv = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  int m_start, m_gap, m_cnt, m_src, m_dst, m_op;
  bit m_cpv, m_ov, m_ow;

  function automatic int map_row(input int la);
    int p;
    if (cfg_interval == 0) return la;
    p = (la + m_start) % ROWS;
    if (p >= m_gap) p++;
    return p;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_start = 0; m_gap = ROWS; m_cnt = 0; m_cpv = 0; m_ov = 0; m_ow = 0; m_op = 0;
      m_src = 0; m_dst = 0;
    end else begin
      bit acc;
      acc = req_valid && !m_cpv;
      m_ov = acc;
      if (acc) begin
        m_op = map_row(int'(req_lrow));
        m_ow = req_write;
      end
      if (m_cpv && copy_done) begin
        m_cpv = 0;
        if (m_gap == 0) begin
          m_gap = ROWS;
          m_start = (m_start + 1) % ROWS;
        end else m_gap--;
      end
      if (cfg_interval == 0) m_cnt = 0;
      else if (acc && req_write) begin
        if (m_cnt + 1 >= int'(cfg_interval)) begin
          m_cnt = 0;
          m_cpv = 1;
          m_dst = m_gap;
          m_src = (m_gap == 0) ? ROWS : m_gap - 1;
        end else m_cnt++;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(req_ready == !m_cpv, "R6 req_ready", req_ready, !m_cpv);
      chk(out_valid == m_ov, "R3 out_valid", out_valid, m_ov);
      if (m_ov) begin
        chk(out_prow == m_op, "R2 out_prow", out_prow, m_op);
        chk(out_write == m_ow, "R3 out_write", out_write, m_ow);
      end
      chk(copy_valid == m_cpv, "R4 copy_valid", copy_valid, m_cpv);
      if (m_cpv) begin
        chk(copy_src == m_src, "R5,R7 copy_src", copy_src, m_src);
        chk(copy_dst == m_dst, "R5,R7 copy_dst", copy_dst, m_dst);
      end
      if (copy_valid && !prev_cv) begin
        copies_seen++;
        chk(out_valid && out_write, "R9 output with copy", out_valid, 1);
      end
      prev_cv = copy_valid;
    end else prev_cv = 0;
  end

  // copy engine with varying latency
  initial begin
    int wait_c = 0;
    int lat = 0;
    forever begin
      @(negedge clk);
      if (copy_done) copy_done = 0;
      else if (copy_valid) begin
        if (wait_c >= lat) begin
          copy_done = 1;
          wait_c = 0;
          lat = (lat + 1) % 4;
        end else wait_c++;
      end
    end
  end

  task automatic send(input bit wr, input int row);
    req_valid = 1; req_write = wr; req_lrow = LA_W'(row);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle_wait();
    while (copy_valid || copy_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle_wait();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    copies_seen = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(copy_valid == 0, "R1 copy_valid after reset", copy_valid, 0);
    for (int r = 0; r < ROWS; r++) begin
      send(0, r);
      chk(out_prow == r, "R1 identity map", out_prow, r);
    end

    // R4 reads never copy
    do_reset();
    cfg_interval = 2;
    for (int i = 0; i < 40; i++) send(0, i % ROWS);
    chk(copies_seen == 0, "R4 reads no copy", copies_seen, 0);
    send(1, 3);
    @(negedge clk);
    chk(copies_seen == 0, "R4 one write no copy", copies_seen, 0);
    send(1, 5);
    chk(copy_valid == 1, "R4 second write copies", copy_valid, 1);
    chk(req_ready == 0, "R6 stall during copy", req_ready, 0);

    // R10 full rotation with interval 4
    do_reset();
    cfg_interval = 4;
    for (int i = 0; i < (ROWS + 1) * 4; i++) send(1, (i * 7) % ROWS);
    idle_wait();
    chk(copies_seen == ROWS + 1, "R10 copy count", copies_seen, ROWS + 1);
    for (int r = 0; r < ROWS; r++) begin
      send(0, r);
      chk(out_prow == (r + 1) % ROWS, "R10 rotated map", out_prow, (r + 1) % ROWS);
    end

    // interval 1: every write copies, mixed with reads (R9)
    cfg_interval = 1;
    for (int i = 0; i < 60; i++) send((i % 3) != 0, (i * 5) % ROWS);
    idle_wait();

    // R8 bypass
    cfg_interval = 0;
    copies_seen = 0;
    for (int i = 0; i < 30; i++) begin
      send(i % 2, (i * 3) % ROWS);
      chk(out_prow == (i * 3) % ROWS, "R8 bypass map", out_prow, (i * 3) % ROWS);
    end
    @(negedge clk);
    chk(copies_seen == 0, "R8 no copies", copies_seen, 0);

    // back to remapping, odd interval
    cfg_interval = 3;
    for (int i = 0; i < 90; i++) send((i % 4) != 1, (i * 11) % ROWS);
    idle_wait();
    finish_run();
  end
endmodule